// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and calendar date as a set of packed-BCD registers. A single-cycle enable pulse, one per second from an external prescaler, advances the count: seconds roll into minutes, minutes into hours on a 24-hour dial, and midnight steps both a free-running day-of-week counter and the date. The date follows the length of the current month, February included, and the month carries into a two-digit year.

A host can overwrite any field at any time through a parallel load port. One mask bit per field selects the targets, and a shared data byte gives the value. All seven fields are visible in parallel on registered outputs. The leap-year rule counts every year whose two-digit value is a multiple of four. This is correct for the years 2000 to 2099.

Top module: `bcd_calendar`

## Requirements
- R1: While `rst_n` is low at a clock edge, the fields reset to sec=00, min=00, hour=00, dow=1, date=01, month=01 and year=00.
- R2: With `tick` low and `ld_we` all zero, no field changes.
- R3: Seconds and minutes count 00 to 59 in packed BCD. The low digit goes from 9 to 0 and carries into the high digit. A seconds wrap carries into minutes on the same tick.
- R4: Hours count 00 to 23. At 23:59:59 a tick gives 00:00:00 and carries into both day of week and date.
- R5: Day of week counts 1 to 7 and returns to 1 on the midnight carry, regardless of the date value.
- R6: The date returns to 01 on the midnight carry when it is at or above the month's last day. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 for February in a non-leap year. Otherwise the date increments.
- R7: February has 29 days when the BCD year is a multiple of four: an even tens digit with a ones digit of 0, 4 or 8, or an odd tens digit with a ones digit of 2 or 6. Year 00 is a leap year.
- R8: The month counts 01 to 12. A date wrap in month 12 gives month 01 and increments the year. The year counts 00 to 99 and then returns to 00.
- R9: `ld_we` bit 0 selects seconds, bit 1 minutes, bit 2 hours, bit 3 day of week, bit 4 date, bit 5 month and bit 6 year. A set bit writes `ld_data` into that field at the clock edge, and this load takes priority over any increment of that field. The carries into the other fields are computed from the values held before the edge.
- R10: All outputs are registered. A tick or load presented before an edge shows on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| ld_we | input | 7 | Per-field load mask (bit order in R9) |
| ld_data | input | 8 | Packed-BCD value to load |
| sec | output | 8 | Seconds, BCD 00-59 |
| min | output | 8 | Minutes, BCD 00-59 |
| hour | output | 8 | Hours, BCD 00-23 |
| dow | output | 8 | Day of week, 1-7 |
| date | output | 8 | Day of month, BCD 01-31 |
| month | output | 8 | Month, BCD 01-12 |
| year | output | 8 | Year, BCD 00-99 |

## Verification
The bench drives a full midnight into each kind of month end. A wrong month table would either show a day 31 in a 30-day month or skip day 30 or 31. For February it uses years 00, 12, 24, 10 and 23: a leap test that reads the year as binary, or ignores the tens digit, gives 29 where 28 is due or the reverse. A year-end at 99 catches a year that rolls to A0 or fails to carry, and a tick at 9 seconds catches a counter that steps to 0A. A load that arrives with a tick at 59 seconds checks that the load beats the increment while the minute carry still goes through.

// File: rtl/bcd_cal_pkg.sv
// Shared widths, field indices and the BCD increment helper for the
// calendar counter. Assumes every field is a two-digit packed BCD byte.
package bcd_cal_pkg;
    localparam int DIGIT_W    = 4;
    localparam int FIELD_W    = 2 * DIGIT_W;
    localparam int NUM_FIELDS = 7;

    // Field indices; also the bit positions of the load mask.
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    typedef logic [FIELD_W-1:0] bcd_t;

    // Add one to a valid two-digit BCD value (caller handles the top wrap).
    function automatic bcd_t bcd_next(bcd_t v);
        bcd_t r;
        if (v[DIGIT_W-1:0] == DIGIT_W'(9))
            r = {v[FIELD_W-1:DIGIT_W] + DIGIT_W'(1), {DIGIT_W{1'b0}}};
        else
            r = v + FIELD_W'(1);
        return r;
    endfunction
endpackage

// File: rtl/bcd_cal_field.sv
// One BCD field register. It increments on inc and returns to RST_VAL when
// the value is at or above last. A load overrides both. Assumes a valid
// BCD value is loaded.
module bcd_cal_field
    import bcd_cal_pkg::*;
#(
    parameter bcd_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  bcd_t last,
    input  logic ld,
    input  bcd_t ld_val,
    output bcd_t val,
    output logic at_last
);
    // Field has reached (or passed) its last legal value.
    assign at_last = (val >= last);

    // Register update: reset, then load, then count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= RST_VAL;
        else if (ld)
            val <= ld_val;
        else if (inc)
            val <= at_last ? RST_VAL : bcd_next(val);
    end
endmodule

// File: rtl/bcd_cal_month_len.sv
// Last day of the month in BCD for a BCD month and two-digit BCD year.
// The leap test is "year is a multiple of 4", applied digit-wise.
module bcd_cal_month_len
    import bcd_cal_pkg::*;
(
    input  bcd_t month,
    input  bcd_t year,
    output bcd_t last_day
);
    logic [DIGIT_W-1:0] ones;
    logic               tens_odd;
    logic               leap;

    assign ones     = year[DIGIT_W-1:0];
    assign tens_odd = year[DIGIT_W];

    // Multiple of four: odd tens need ones 2/6, even tens need 0/4/8.
    always_comb begin
        if (tens_odd)
            leap = (ones == DIGIT_W'(2)) || (ones == DIGIT_W'(6));
        else
            leap = (ones == DIGIT_W'(0)) || (ones == DIGIT_W'(4)) ||
                   (ones == DIGIT_W'(8));
    end

    // Month length lookup.
    always_comb begin
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
// BCD calendar counter: seven field registers linked by a carry chain.
// The chain runs sec -> min -> hour -> {dow, date} -> month -> year.
// Assumes tick is a single-cycle pulse and loaded values are valid BCD.
module bcd_calendar
    import bcd_cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_FIELDS-1:0] ld_we,
    input  logic [FIELD_W-1:0]    ld_data,
    output logic [FIELD_W-1:0]    sec,
    output logic [FIELD_W-1:0]    min,
    output logic [FIELD_W-1:0]    hour,
    output logic [FIELD_W-1:0]    dow,
    output logic [FIELD_W-1:0]    date,
    output logic [FIELD_W-1:0]    month,
    output logic [FIELD_W-1:0]    year
);
    localparam bcd_t FIRST [NUM_FIELDS] =
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    bcd_t                  fld [NUM_FIELDS];
    bcd_t                  lim [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] at_last;
    bcd_t                  month_last;

    bcd_cal_month_len u_mlen (
        .month    (fld[F_MONTH]),
        .year     (fld[F_YEAR]),
        .last_day (month_last)
    );

    // Per-field wrap limits; only the date limit varies.
    always_comb begin
        lim[F_SEC]   = 8'h59;
        lim[F_MIN]   = 8'h59;
        lim[F_HOUR]  = 8'h23;
        lim[F_DOW]   = 8'h07;
        lim[F_DATE]  = month_last;
        lim[F_MONTH] = 8'h12;
        lim[F_YEAR]  = 8'h99;
    end

    // Carry chain built from current values, independent of loads.
    always_comb begin
        inc[F_SEC]   = tick;
        inc[F_MIN]   = inc[F_SEC]   & at_last[F_SEC];
        inc[F_HOUR]  = inc[F_MIN]   & at_last[F_MIN];
        inc[F_DOW]   = inc[F_HOUR]  & at_last[F_HOUR];
        inc[F_DATE]  = inc[F_HOUR]  & at_last[F_HOUR];
        inc[F_MONTH] = inc[F_DATE]  & at_last[F_DATE];
        inc[F_YEAR]  = inc[F_MONTH] & at_last[F_MONTH];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        bcd_cal_field #(.RST_VAL(FIRST[i])) u_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc[i]),
            .last    (lim[i]),
            .ld      (ld_we[i]),
            .ld_val  (ld_data),
            .val     (fld[i]),
            .at_last (at_last[i])
        );
    end

    assign sec   = fld[F_SEC];
    assign min   = fld[F_MIN];
    assign hour  = fld[F_HOUR];
    assign dow   = fld[F_DOW];
    assign date  = fld[F_DATE];
    assign month = fld[F_MONTH];
    assign year  = fld[F_YEAR];
endmodule

// File: rtl/bcd_calendar_chk.sv
// Protocol checker for the calendar counter, attached by bind.
// Assumes only valid BCD values are loaded.
module bcd_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [6:0] ld_we,
    input logic [7:0] ld_data,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [7:0] dow,
    input logic [7:0] date,
    input logic [7:0] month,
    input logic [7:0] year
);
    logic quiet;
    logic eod;
    assign quiet = (ld_we == 7'd0);
    assign eod   = tick && quiet && sec == 8'h59 && min == 8'h59 && hour == 8'h23;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && quiet) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                              $stable(dow) && $stable(date) && $stable(month) &&
                              $stable(year)));
    // R9
    load_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we[0] |=> sec == $past(ld_data));
    // R9
    load_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we[4] |=> date == $past(ld_data));
    // R3
    sec_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec[3:0] <= 4'd9);
    // R4
    midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eod |=> (hour == 8'h00 && min == 8'h00 && sec == 8'h00));
    // R5
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eod && dow == 8'h07) |=> dow == 8'h01);
    // R7
    leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eod && month == 8'h02 && date == 8'h28 && year[3:0] == 4'h4 && !year[4])
        |=> date == 8'h29);
    // R8
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eod && month == 8'h12 && date == 8'h31 && year == 8'h99)
        |=> (year == 8'h00 && month == 8'h01 && date == 8'h01));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_we(ld_we), .ld_data(ld_data),
    .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date),
    .month(month), .year(year)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
// Bench: directed rollovers plus seeded random ticks and loads, checked
// every cycle against a behavioural model kept in plain integers.
module bcd_calendar_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] ld_we = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] sec, min, hour, dow, date, month, year;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year;

    always #2 clk = ~clk;

    bcd_calendar uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_we(ld_we), .ld_data(ld_data),
        .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date),
        .month(month), .year(year)
    );

    function automatic logic [7:0] i2b(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int b2i(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // Model next state; carries use values held before the edge (R9).
    task automatic model(bit t, logic [6:0] m, logic [7:0] d);
        bit c_s, c_m, c_h, c_d, c_mo;
        int v;
        v    = b2i(d);
        c_s  = t && m_sec >= 59;
        c_m  = c_s && m_min >= 59;
        c_h  = c_m && m_hour >= 23;
        c_d  = c_h && m_date >= dim(m_mon, m_year);
        c_mo = c_d && m_mon >= 12;
        if (m[0]) m_sec = v; else if (t) m_sec = c_s ? 0 : m_sec + 1;
        if (m[1]) m_min = v; else if (c_s) m_min = c_m ? 0 : m_min + 1;
        if (m[2]) m_hour = v; else if (c_m) m_hour = c_h ? 0 : m_hour + 1;
        if (m[3]) m_dow = v; else if (c_h) m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
        if (m[4]) m_date = v; else if (c_h) m_date = c_d ? 1 : m_date + 1;
        if (m[5]) m_mon = v; else if (c_d) m_mon = c_mo ? 1 : m_mon + 1;
        if (m[6]) m_year = v; else if (c_mo) m_year = (m_year >= 99) ? 0 : m_year + 1;
    endtask

    task automatic cmp(string tag, string name, logic [7:0] act, int exp);
        total++;
        if (act !== i2b(exp)) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, name, act, i2b(exp));
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "sec", sec, m_sec);
        cmp(tag, "min", min, m_min);
        cmp(tag, "hour", hour, m_hour);
        cmp(tag, "dow", dow, m_dow);
        cmp(tag, "date", date, m_date);
        cmp(tag, "month", month, m_mon);
        cmp(tag, "year", year, m_year);
    endtask

    // Drive at the falling edge, let one rising edge pass, check (R10).
    task automatic cycle(bit t, logic [6:0] m, logic [7:0] d, string tag);
        tick = t; ld_we = m; ld_data = d;
        model(t, m, d);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_all(int h, int mi, int s, int dw, int dt, int mo, int y);
        cycle(0, 7'b0000001, i2b(s), "R9");
        cycle(0, 7'b0000010, i2b(mi), "R9");
        cycle(0, 7'b0000100, i2b(h), "R9");
        cycle(0, 7'b0001000, i2b(dw), "R9");
        cycle(0, 7'b0010000, i2b(dt), "R9");
        cycle(0, 7'b0100000, i2b(mo), "R9");
        cycle(0, 7'b1000000, i2b(y), "R9");
    endtask

    task automatic midnight(int dw, int dt, int mo, int y, string tag);
        set_all(23, 59, 59, dw, dt, mo, y);
        cycle(1, 7'd0, 8'h00, tag);
        cycle(0, 7'd0, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        repeat (3) cycle(0, 7'd0, 8'h00, "R2");

        // R3: digit carry and seconds-to-minutes carry
        set_all(10, 9, 9, 2, 5, 3, 20);
        cycle(1, 7'd0, 8'h00, "R3");
        set_all(10, 9, 59, 2, 5, 3, 20);
        cycle(1, 7'd0, 8'h00, "R3");
        set_all(10, 59, 59, 2, 5, 3, 20);
        cycle(1, 7'd0, 8'h00, "R3");

        // R4, R5: midnight carries, dow wrap independent of date
        midnight(7, 15, 6, 30, "R4");
        midnight(3, 31, 5, 30, "R5");

        // R6: month ends
        midnight(1, 30, 4, 21, "R6");
        midnight(1, 30, 11, 21, "R6");
        midnight(1, 30, 1, 21, "R6");
        midnight(1, 31, 1, 21, "R6");
        midnight(1, 28, 2, 23, "R6");
        midnight(1, 31, 9, 21, "R6");

        // R7: leap years
        midnight(1, 28, 2, 24, "R7");
        midnight(1, 29, 2, 24, "R7");
        midnight(1, 28, 2, 0, "R7");
        midnight(1, 28, 2, 12, "R7");
        midnight(1, 28, 2, 10, "R7");

        // R8: year end
        midnight(4, 31, 12, 99, "R8");
        midnight(4, 31, 12, 41, "R8");

        // R9: load beats increment, other carries still flow
        set_all(8, 20, 59, 2, 5, 3, 20);
        cycle(1, 7'b0000001, 8'h30, "R9");
        cycle(1, 7'b0100000, 8'h07, "R9");

        // Random ticks and loads
        for (int n = 0; n < 4000; n++) begin
            bit t;
            int f, v;
            t = ($urandom % 10) < 7;
            if ($urandom % 10 == 0) begin
                f = $urandom % 7;
                case (f)
                    0, 1: v = $urandom % 60;
                    2: v = $urandom % 24;
                    3: v = 1 + $urandom % 7;
                    4: v = 1 + $urandom % 31;
                    5: v = 1 + $urandom % 12;
                    default: v = $urandom % 100;
                endcase
                cycle(t, 7'(1 << f), i2b(v), "R9");
            end else begin
                cycle(t, 7'd0, 8'h00, "R3");
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule